// File: doc/BRIEF.md
# Banked GPIO Controller with Alternate-Function Steering

This block is a register-mapped general-purpose I/O controller for a configurable number of pins. The pins are split into 32-pin banks. Every register kind is repeated once per bank, so a pin's control bits sit in one word of each kind. Software can set or clear output bits without a read-modify-write. It can also load the output word directly, choose the direction of each pin and read back the synchronized pad inputs.

Each pin has an interrupt path. A rising edge on a pin that is in GPIO mode latches a status bit. The status bit is then masked by an enable bit, and the enabled bits are ORed into one interrupt line.

A two-bit function code per pin steers the pad. Code 0 connects the pad to the GPIO registers, and codes 1 to 3 connect it to one of three peripheral signal pairs. The two bits of the code live in two separate registers, at the pin's bit position in each.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The bank count B is 1 + (NUM_PINS-1)/32, using integer division. The register kind k is reached at byte address (k*B + n)*4 for bank n, and pin p is bit p mod 32 of bank p/32. The kinds are: 0 set, 1 clear, 2 output value, 3 input, 4 output enable, 5 interrupt status, 6 interrupt enable, 7 interrupt identity, 8 function bit 0, 9 function bit 1. Reads are combinational from the current address.
- R2: A write to kind 0 sets the output bits where the data holds a 1. A write to kind 1 clears those bits. Data bits that are 0 leave their outputs unchanged.
- R3: A write to kind 2 loads the output bits of that bank, and a read of kind 2 returns them.
- R4: Kinds 4, 6, 8 and 9 are read/write. An output-enable bit of 1 drives the pad (pad_oe high) while the pin is in GPIO mode.
- R5: A read of kind 3 returns pad_in through a two-flip-flop synchronizer. A change on pad_in is visible after the second rising clock edge, whatever the direction or function of the pin.
- R6: A status bit sets one clock edge after the synchronized input of a GPIO-mode pin (function code 0) has risen. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a set and a clear coincide in the same cycle, the set wins. Pins with a non-zero function code never latch a status bit.
- R7: The identity register reads the status AND the enable. irq_out is high exactly when any identity bit in any bank is 1.
- R8: A pin's function code is {function bit 1, function bit 0}. Code 0 drives pad_out and pad_oe from the GPIO output and output-enable bits. Code c in 1..3 drives them from periph_out[3*p+c-1] and periph_oe[3*p+c-1].
- R9: The following reads return zero: kinds 0 and 1, kinds 10 and above, unaligned addresses (address bits [1:0] not 0), and bits for pins at or above NUM_PINS. Writes to unmapped kinds, to unaligned addresses, or to missing pins change nothing.
- R10: After reset, every register, the status and the synchronizer are zero, pad_oe is zero and irq_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | NUM_PINS | Pad input values |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| periph_out | input | 3*NUM_PINS | Peripheral output per pin and function slot |
| periph_oe | input | 3*NUM_PINS | Peripheral output enable per pin and function slot |
| irq_out | output | 1 | Combined interrupt |

## Verification
Each wrong internal state shows up at the ports soon after it arises:
- A wrong output, direction or function bit appears on pad_out or pad_oe in the cycle after the write that caused it.
- A wrong status or enable bit flips irq_out in that same cycle, and reading the status or identity word shows it too.
- A bad synchronizer depth is visible one edge early or late on the input read.
- An edge detector that ignores function mode leaves a stray status bit, which appears on the identity read.

Since every bank reuses the same kinds at a stride of B, a decoding slip lands on the wrong bank's word. It is exposed by reading back a bank other than the one written.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_W = 32;
  localparam int NUM_REG_TYPES = 10;

  typedef enum logic [3:0] {
    RT_SET   = 4'd0,
    RT_CLR   = 4'd1,
    RT_OUT   = 4'd2,
    RT_IN    = 4'd3,
    RT_OE    = 4'd4,
    RT_STAT  = 4'd5,
    RT_ENA   = 4'd6,
    RT_IDENT = 4'd7,
    RT_FSEL0 = 4'd8,
    RT_FSEL1 = 4'd9
  } reg_type_e;

  // Number of 32-pin banks for a given pin count (R1).
  function automatic int bank_count(int pins);
    return 1 + (pins - 1) / REG_W;
  endfunction
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode import gpio_bank_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int BANKS  = 1,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_type_e         rtype,
  output logic [BANK_W-1:0] bank,
  output logic              hit
);
  int unsigned word_idx;
  int unsigned type_idx;

  // Kind-major layout: word = kind * BANKS + bank.
  always_comb begin
    word_idx = 32'(addr[ADDR_W-1:2]);
    type_idx = word_idx / BANKS;
    bank     = BANK_W'(word_idx % BANKS);
    rtype    = reg_type_e'(type_idx[3:0]);
    hit      = (addr[1:0] == 2'b00) && (type_idx < NUM_REG_TYPES);
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int NUM_PINS = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] gpio_mode,
  input  logic [NUM_PINS-1:0] w1c_mask,
  input  logic [NUM_PINS-1:0] ena,
  output logic [NUM_PINS-1:0] in_sync,
  output logic [NUM_PINS-1:0] rise,
  output logic [NUM_PINS-1:0] stat,
  output logic [NUM_PINS-1:0] ident,
  output logic                irq
);
  logic [NUM_PINS-1:0] sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      stat    <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      stat    <= (stat & ~w1c_mask) | rise;  // set beats clear
    end
  end

  assign in_sync = sync2_q;
  assign rise    = sync2_q & ~prev_q & gpio_mode;
  assign ident   = stat & ena;
  assign irq     = |ident;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NUM_PINS = 22
) (
  input  logic [NUM_PINS-1:0]   fsel0,
  input  logic [NUM_PINS-1:0]   fsel1,
  input  logic [NUM_PINS-1:0]   gpio_out,
  input  logic [NUM_PINS-1:0]   gpio_oe,
  input  logic [3*NUM_PINS-1:0] periph_out,
  input  logic [3*NUM_PINS-1:0] periph_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   gpio_mode
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [1:0] code;
    logic [1:0] slot;
    logic [2:0] po, pe;
    assign code = {fsel1[p], fsel0[p]};
    assign slot = code - 2'd1;
    assign po   = periph_out[3*p +: 3];
    assign pe   = periph_oe[3*p +: 3];
    assign gpio_mode[p] = (code == 2'd0);
    assign pad_out[p]   = (code == 2'd0) ? gpio_out[p] : po[slot];
    assign pad_oe[p]    = (code == 2'd0) ? gpio_oe[p]  : pe[slot];
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl import gpio_bank_pkg::*; #(
  parameter int NUM_PINS = 22,
  parameter int ADDR_W   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  input  logic [3*NUM_PINS-1:0] periph_out,
  input  logic [3*NUM_PINS-1:0] periph_oe,
  output logic                  irq_out
);
  localparam int BANKS  = bank_count(NUM_PINS);
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int SPAN   = BANKS * REG_W;

  reg_type_e           dec_type;
  logic [BANK_W-1:0]   dec_bank;
  logic                dec_hit;
  logic                wr_ok, wr_unmapped;
  logic [NUM_REG_TYPES-1:0] wr_type;

  logic [NUM_PINS-1:0] sel_pin, wbit, wsel;
  logic [NUM_PINS-1:0] set_mask, clr_mask, w1c_mask;
  logic [NUM_PINS-1:0] out_q, oe_q, ena_q, fsel0_q, fsel1_q;
  logic [NUM_PINS-1:0] in_sync, rise_vec, stat_vec, ident_vec, gpio_mode;
  logic [SPAN-1:0]     unused_wide_wdata;

  gpio_bus_decode #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_dec (
    .addr(bus_addr), .rtype(dec_type), .bank(dec_bank), .hit(dec_hit)
  );

  assign wr_ok       = bus_we & dec_hit;
  assign wr_unmapped = bus_we & ~dec_hit;

  always_comb begin
    for (int i = 0; i < NUM_REG_TYPES; i++)
      wr_type[i] = wr_ok && (dec_type == reg_type_e'(i[3:0]));
  end

  // Map one bank word onto the pins of that bank.
  assign unused_wide_wdata = {BANKS{bus_wdata}};
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sel
    assign sel_pin[p] = (dec_bank == BANK_W'(p / REG_W));
    assign wbit[p]    = unused_wide_wdata[p];
  end
  assign wsel     = sel_pin & wbit;
  assign set_mask = wr_type[RT_SET]  ? wsel : '0;
  assign clr_mask = wr_type[RT_CLR]  ? wsel : '0;
  assign w1c_mask = wr_type[RT_STAT] ? wsel : '0;

  // Replace the selected bank's bits of a vector with the write data.
  function automatic logic [NUM_PINS-1:0] load_bank(
    logic [NUM_PINS-1:0] old, logic [NUM_PINS-1:0] sel, logic [NUM_PINS-1:0] d);
    return (old & ~sel) | (d & sel);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      oe_q    <= '0;
      ena_q   <= '0;
      fsel0_q <= '0;
      fsel1_q <= '0;
    end else begin
      if (wr_type[RT_OUT]) out_q <= load_bank(out_q, sel_pin, wbit);
      else                 out_q <= (out_q & ~clr_mask) | set_mask;
      if (wr_type[RT_OE])    oe_q    <= load_bank(oe_q, sel_pin, wbit);
      if (wr_type[RT_ENA])   ena_q   <= load_bank(ena_q, sel_pin, wbit);
      if (wr_type[RT_FSEL0]) fsel0_q <= load_bank(fsel0_q, sel_pin, wbit);
      if (wr_type[RT_FSEL1]) fsel1_q <= load_bank(fsel1_q, sel_pin, wbit);
    end
  end

  gpio_irq_unit #(.NUM_PINS(NUM_PINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .gpio_mode(gpio_mode),
    .w1c_mask(w1c_mask), .ena(ena_q), .in_sync(in_sync), .rise(rise_vec),
    .stat(stat_vec), .ident(ident_vec), .irq(irq_out)
  );

  gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .fsel0(fsel0_q), .fsel1(fsel1_q), .gpio_out(out_q), .gpio_oe(oe_q),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .gpio_mode(gpio_mode)
  );

  // Pick one bank word out of a zero-padded pin vector.
  function automatic logic [REG_W-1:0] bank_word(
    logic [NUM_PINS-1:0] v, logic [BANK_W-1:0] b);
    logic [SPAN-1:0] wide;
    wide = '0;
    wide[NUM_PINS-1:0] = v;
    return wide[int'(b)*REG_W +: REG_W];
  endfunction

  always_comb begin
    unique case (dec_type)
      RT_OUT:   bus_rdata = bank_word(out_q, dec_bank);
      RT_IN:    bus_rdata = bank_word(in_sync, dec_bank);
      RT_OE:    bus_rdata = bank_word(oe_q, dec_bank);
      RT_STAT:  bus_rdata = bank_word(stat_vec, dec_bank);
      RT_ENA:   bus_rdata = bank_word(ena_q, dec_bank);
      RT_IDENT: bus_rdata = bank_word(ident_vec, dec_bank);
      RT_FSEL0: bus_rdata = bank_word(fsel0_q, dec_bank);
      RT_FSEL1: bus_rdata = bank_word(fsel1_q, dec_bank);
      default:  bus_rdata = '0;
    endcase
    if (!dec_hit) bus_rdata = '0;
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_PINS = 22
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_unmapped,
  input logic [NUM_PINS-1:0] set_mask,
  input logic [NUM_PINS-1:0] clr_mask,
  input logic [NUM_PINS-1:0] w1c_mask,
  input logic [NUM_PINS-1:0] rise_vec,
  input logic [NUM_PINS-1:0] stat_vec,
  input logic [NUM_PINS-1:0] ena_vec,
  input logic [NUM_PINS-1:0] out_vec,
  input logic [NUM_PINS-1:0] oe_vec,
  input logic [NUM_PINS-1:0] fsel0_vec,
  input logic [NUM_PINS-1:0] fsel1_vec,
  input logic                irq_out
);
  a_r2_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((out_vec & $past(set_mask)) == $past(set_mask)));

  a_r2_clr_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((out_vec & $past(clr_mask)) == '0));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vec != '0) |=> ((stat_vec & $past(rise_vec)) == $past(rise_vec)));

  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((w1c_mask & ~rise_vec) != '0) |=> ((stat_vec & $past(w1c_mask & ~rise_vec)) == '0));

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_vec == '0) |-> !irq_out);

  a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> ($stable(out_vec) && $stable(oe_vec) && $stable(ena_vec)
                     && $stable(fsel0_vec) && $stable(fsel1_vec)));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_unmapped(wr_unmapped),
  .set_mask(set_mask), .clr_mask(clr_mask), .w1c_mask(w1c_mask),
  .rise_vec(rise_vec), .stat_vec(stat_vec), .ena_vec(ena_q),
  .out_vec(out_q), .oe_vec(oe_q), .fsel0_vec(fsel0_q), .fsel1_vec(fsel1_q),
  .irq_out(irq_out)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 40;
  localparam int AW = 10;
  localparam int BANKS = 1 + (NP - 1) / 32;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic [3*NP-1:0] periph_out, periph_oe;
  logic irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .periph_out(periph_out),
    .periph_oe(periph_oe), .irq_out(irq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference state, one bit per pin.
  bit m_out[NP], m_oe[NP], m_ena[NP], m_f0[NP], m_f1[NP];
  bit m_stat[NP], m_s1[NP], m_s2[NP], m_prev[NP], m_rise[NP];
  int mw, mt, mb, mp;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_out[p] = 0; m_oe[p] = 0; m_ena[p] = 0; m_f0[p] = 0; m_f1[p] = 0;
        m_stat[p] = 0; m_s1[p] = 0; m_s2[p] = 0; m_prev[p] = 0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        m_rise[p] = m_s2[p] && !m_prev[p] && !m_f0[p] && !m_f1[p];
        m_prev[p] = m_s2[p];
        m_s2[p] = m_s1[p];
        m_s1[p] = pad_in[p];
      end
      if (bus_we && bus_addr[1:0] == 2'b00) begin
        mw = int'(bus_addr) / 4; mt = mw / BANKS; mb = mw % BANKS;
        for (int b = 0; b < 32; b++) begin
          mp = mb * 32 + b;
          if (mp < NP) begin
            case (mt)
              0: if (bus_wdata[b]) m_out[mp] = 1;
              1: if (bus_wdata[b]) m_out[mp] = 0;
              2: m_out[mp] = bus_wdata[b];
              4: m_oe[mp] = bus_wdata[b];
              5: if (bus_wdata[b]) m_stat[mp] = 0;
              6: m_ena[mp] = bus_wdata[b];
              8: m_f0[mp] = bus_wdata[b];
              9: m_f1[mp] = bus_wdata[b];
              default: ;
            endcase
          end
        end
      end
      for (int p = 0; p < NP; p++) if (m_rise[p]) m_stat[p] = 1;
    end
  end

  function automatic logic [31:0] exp_read(logic [AW-1:0] a);
    logic [31:0] r = '0;
    int w, t, bk, p;
    if (a[1:0] != 2'b00) return '0;
    w = int'(a) / 4; t = w / BANKS; bk = w % BANKS;
    for (int b = 0; b < 32; b++) begin
      p = bk * 32 + b;
      if (p < NP) begin
        case (t)
          2: r[b] = m_out[p];
          3: r[b] = m_s2[p];
          4: r[b] = m_oe[p];
          5: r[b] = m_stat[p];
          6: r[b] = m_ena[p];
          7: r[b] = m_stat[p] & m_ena[p];
          8: r[b] = m_f0[p];
          9: r[b] = m_f1[p];
          default: r[b] = 0;
        endcase
      end
    end
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_pad(bit want_oe);
    logic [NP-1:0] v;
    int c;
    for (int p = 0; p < NP; p++) begin
      c = (m_f1[p] ? 2 : 0) + (m_f0[p] ? 1 : 0);
      if (c == 0) v[p] = want_oe ? m_oe[p] : m_out[p];
      else        v[p] = want_oe ? periph_oe[3*p+c-1] : periph_out[3*p+c-1];
    end
    return v;
  endfunction

  function automatic bit exp_irq();
    bit r = 0;
    for (int p = 0; p < NP; p++) if (m_stat[p] && m_ena[p]) r = 1;
    return r;
  endfunction

  function automatic logic [AW-1:0] addr_of(int kind, int bank);
    return AW'((kind * BANKS + bank) * 4);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock, then compare every output against the model.
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    chk("R1 per-cycle read", 64'(bus_rdata), 64'(exp_read(bus_addr)));
    chk("R8 per-cycle pad_out", 64'(pad_out), 64'(exp_pad(0)));
    chk("R4 per-cycle pad_oe", 64'(pad_oe), 64'(exp_pad(1)));
    chk("R7 per-cycle irq", 64'(irq_out), 64'(exp_irq()));
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    cycle();
    bus_we = 0;
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, 64'(bus_rdata), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3*NP; i++) begin
      periph_out[i] = (((i / 3) + (i % 3)) % 2) == 1;
      periph_oe[i]  = (i % 3) != 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 pad_oe after reset", 64'(pad_oe), 64'd0);
    chk("R10 irq after reset", 64'(irq_out), 64'd0);
    rd_chk("R10 out after reset", addr_of(2, 0), 32'h0);
    rd_chk("R10 stat after reset", addr_of(5, 1), 32'h0);
    // R3 / R1 / R9 direct load per bank
    wr(addr_of(2, 0), 32'hA5A5_A5A5);
    rd_chk("R3 out bank0 load", addr_of(2, 0), 32'hA5A5_A5A5);
    wr(addr_of(2, 1), 32'hFFFF_FFFF);
    rd_chk("R9 out bank1 upper bits zero", addr_of(2, 1), 32'h0000_00FF);
    chk("R1 bank1 pins on pad_out", 64'(pad_out[39:32]), 64'hFF);
    // R2 atomic set/clear
    wr(addr_of(0, 0), 32'h0000_000F);
    rd_chk("R2 set", addr_of(2, 0), 32'hA5A5_A5AF);
    wr(addr_of(1, 0), 32'h0000_00AE);
    rd_chk("R2 clear", addr_of(2, 0), 32'hA5A5_A501);
    rd_chk("R9 set kind reads zero", addr_of(0, 0), 32'h0);
    // R4 output enable
    wr(addr_of(4, 0), 32'h0000_FFFF);
    chk("R4 pad_oe low pins", 64'(pad_oe[15:0]), 64'hFFFF);
    chk("R4 pad_oe bank1", 64'(pad_oe[39:32]), 64'h0);
    // R5 synchronizer latency
    pad_in = 40'h12_3456_789A;
    bus_addr = addr_of(3, 0);
    cycle();
    rd_chk("R5 input after one edge", addr_of(3, 0), 32'h0);
    cycle();
    rd_chk("R5 input after two edges", addr_of(3, 0), 32'h3456_789A);
    rd_chk("R5 input bank1", addr_of(3, 1), 32'h0000_0012);
    cycle();
    // R6 latch and W1C
    rd_chk("R6 status bank0 latched", addr_of(5, 0), 32'h3456_789A);
    rd_chk("R6 status bank1 latched", addr_of(5, 1), 32'h0000_0012);
    wr(addr_of(5, 0), 32'h0000_000A);
    rd_chk("R6 w1c clears", addr_of(5, 0), 32'h3456_7890);
    wr(addr_of(5, 0), 32'h0);
    rd_chk("R6 zero write keeps", addr_of(5, 0), 32'h3456_7890);
    pad_in[0] = 1;
    cycle(); cycle();
    wr(addr_of(5, 0), 32'h0000_0001);
    rd_chk("R6 set wins over clear", addr_of(5, 0), 32'h3456_7891);
    // R7 masking and identity
    chk("R7 irq masked", 64'(irq_out), 64'd0);
    wr(addr_of(6, 0), 32'h0000_0010);
    chk("R7 irq raised", 64'(irq_out), 64'd1);
    rd_chk("R7 identity bank0", addr_of(7, 0), 32'h0000_0010);
    wr(addr_of(5, 0), 32'h0000_0010);
    chk("R7 irq dropped after w1c", 64'(irq_out), 64'd0);
    wr(addr_of(6, 1), 32'h0000_0002);
    chk("R7 irq from bank1", 64'(irq_out), 64'd1);
    rd_chk("R7 identity bank1", addr_of(7, 1), 32'h0000_0002);
    wr(addr_of(6, 1), 32'h0);
    // R8 function steering: pin1 code1, pin2 code2, pin3 code3
    wr(addr_of(8, 0), 32'h0000_000A);
    wr(addr_of(9, 0), 32'h0000_000C);
    chk("R8 pad_out steered", 64'(pad_out[3:1]), 64'b111);
    chk("R8 pad_oe steered", 64'(pad_oe[3:1]), 64'b110);
    chk("R8 pin0 stays gpio", 64'(pad_out[0]), 64'd1);
    // R6 non-gpio pins do not latch
    wr(addr_of(5, 0), 32'hFFFF_FFFF);
    pad_in = '0;
    repeat (4) cycle();
    wr(addr_of(5, 0), 32'hFFFF_FFFF);
    pad_in[1] = 1; pad_in[5] = 1;
    repeat (4) cycle();
    rd_chk("R6 only gpio pin latches", addr_of(5, 0), 32'h0000_0020);
    // R9 unmapped and unaligned writes ignored
    wr(addr_of(12, 0), 32'hFFFF_FFFF);
    rd_chk("R9 unmapped reads zero", addr_of(12, 0), 32'h0);
    wr(addr_of(2, 0) + AW'(1), 32'h0);
    rd_chk("R9 unaligned write ignored", addr_of(2, 0), 32'hA5A5_A501);
    rd_chk("R9 unaligned read zero", addr_of(2, 0) + AW'(2), 32'h0);
    wr(addr_of(3, 0), 32'hFFFF_FFFF);
    rd_chk("R9 input kind not writable", addr_of(3, 0), 32'h0000_0022);
    repeat (2) cycle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule